// File: doc/BRIEF.md
# Two-Key Register Write Unlock

This block sits on the write path of a 32-bit register bus, in front of a peripheral's configuration registers. It holds two 32-bit key slots at fixed offsets. Each slot has its own magic word. Writes to the protected address window are passed on only while both slots hold their magic words. Writing any other value to either slot locks the window again.

The block produces a per-write qualifier, `fwd_wr_o`, which the register file uses as its write enable. Software locks the gate by writing zero to the two slots and unlocks it by writing the two magic words. The slot contents can be read back through a combinational read port, and the lock state is shown on `unlocked_o`.

Top module: `key_gate`

## Requirements
- R1: After reset both key slots read as zero, `unlocked_o` is 0 and protected writes are not forwarded.
- R2: Writing 0x83E70B13 to offset 0x6C and then 0x95A4F1E0 to offset 0x70 sets `unlocked_o` in the cycle after the second write's clock edge.
- R3: The unlock state depends only on the slot contents, so writing the two magic words in the reverse order also unlocks.
- R4: A write of any non-magic value to either slot clears `unlocked_o` in the cycle after that write's edge.
- R5: Writing zero to both slots leaves the gate locked.
- R6: While locked, a write to an offset in the protected window [PROT_LO, PROT_HI] is dropped: `fwd_wr_o` stays 0 in that cycle.
- R7: While unlocked, a write to the protected window asserts `fwd_wr_o` in the same cycle as `wr_en_i`.
- R8: Writes to offsets outside the protected window that are not slot offsets are always forwarded, whatever the lock state.
- R9: Slot writes are always stored and are never forwarded. `rd_data_o` returns slot 0 contents for read offset 0x6C, slot 1 contents for 0x70, and zero for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset for slot readback |
| rd_data_o | output | 32 | Slot readback data (combinational) |
| fwd_wr_o | output | 1 | Qualified write enable to the register file |
| unlocked_o | output | 1 | High while both slots hold their magic words |

## Verification
The assertions assume each bus write is a single-cycle `wr_en_i` pulse with a stable address and data in that cycle. The two-write unlock property also assumes the two writes arrive in back-to-back cycles. The stimulus drives the inputs at the falling edge and holds them for one full cycle. Random traffic is weighted so that magic, zero and arbitrary slot writes are mixed with writes to protected and unprotected offsets. This makes lock and unlock transitions occur often, both between and during protected writes.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_KEYS = 2;

  localparam logic [DATA_W-1:0] KEY_MAGIC [NUM_KEYS] = '{32'h83E7_0B13, 32'h95A4_F1E0};

  // slot offsets: slot 0 at 0x6C, slot 1 follows at +4
  function automatic int unsigned key_ofs(input int unsigned idx);
    return 32'h6C + 4 * idx;
  endfunction
endpackage

// File: rtl/key_slot.sv
module key_slot #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS    = 0,
  parameter logic [DATA_W-1:0] MAGIC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o,
  output logic              match_o,
  output logic [DATA_W-1:0] val_o
);
  localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(OFS);

  logic [DATA_W-1:0] key_q;

  assign wr_hit_o = (wr_addr_i == SLOT_ADDR);
  assign rd_hit_o = (rd_addr_i == SLOT_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  key_q <= '0;
    else if (wr_en_i && wr_hit_o) key_q <= wr_data_i;
  end

  assign match_o = (key_q == MAGIC);
  assign val_o   = key_q;
endmodule

// File: rtl/win_decode.sv
module win_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter int          PROT_LO = 0,
  parameter int          PROT_HI = 'h5C
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_win_o
);
  int addr_int;
  always_comb begin
    addr_int = int'({1'b0, addr_i});
    in_win_o = (addr_int >= PROT_LO) && (addr_int <= PROT_HI);
  end
endmodule

// File: rtl/key_gate.sv
module key_gate
  import key_gate_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int          PROT_LO = 0,
  parameter int          PROT_HI = 'h5C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [31:0]       rd_data_o,
  output logic              fwd_wr_o,
  output logic              unlocked_o
);
  logic [NUM_KEYS-1:0] wr_hit, rd_hit, match;
  logic [DATA_W-1:0]   slot_val [NUM_KEYS];
  logic                in_win;
  logic                any_key_wr;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_slot
    key_slot #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W),
      .OFS   (key_ofs(g)),
      .MAGIC (KEY_MAGIC[g])
    ) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i),
      .wr_hit_o (wr_hit[g]),
      .rd_hit_o (rd_hit[g]),
      .match_o  (match[g]),
      .val_o    (slot_val[g])
    );
  end

  win_decode #(
    .ADDR_W (ADDR_W),
    .PROT_LO(PROT_LO),
    .PROT_HI(PROT_HI)
  ) u_win (
    .addr_i  (wr_addr_i),
    .in_win_o(in_win)
  );

  assign any_key_wr = |wr_hit;
  assign unlocked_o = &match;
  // slot writes never reach the register file
  assign fwd_wr_o   = wr_en_i && !any_key_wr && (!in_win || unlocked_o);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_KEYS; i++)
      if (rd_hit[i]) rd_data_o = slot_val[i];
  end
endmodule

// File: rtl/key_gate_chk.sv
module key_gate_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int          PROT_LO = 0,
  parameter int          PROT_HI = 'h5C
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic              fwd_wr_o,
  input logic              unlocked_o
);
  localparam logic [ADDR_W-1:0] K0 = ADDR_W'(32'h6C);
  localparam logic [ADDR_W-1:0] K1 = ADDR_W'(32'h70);

  logic is_key, in_win;
  int   a_int;
  always_comb begin
    a_int  = int'({1'b0, wr_addr_i});
    is_key = (wr_addr_i == K0) || (wr_addr_i == K1);
    in_win = (a_int >= PROT_LO) && (a_int <= PROT_HI);
  end

  p_unlock_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == K0 && wr_data_i == 32'h83E7_0B13) ##1
    (wr_en_i && wr_addr_i == K1 && wr_data_i == 32'h95A4_F1E0) |=> unlocked_o);

  p_bad_key_relock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ((wr_addr_i == K0 && wr_data_i != 32'h83E7_0B13) ||
                 (wr_addr_i == K1 && wr_data_i != 32'h95A4_F1E0))) |=> !unlocked_o);

  p_locked_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_win && !is_key && !unlocked_o) |-> !fwd_wr_o);

  p_unlocked_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && in_win && !is_key && unlocked_o) |-> fwd_wr_o);

  p_outside_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !in_win && !is_key) |-> fwd_wr_o);

  p_key_not_fwd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && is_key) |-> !fwd_wr_o);

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> !fwd_wr_o);
endmodule

bind key_gate key_gate_chk #(
  .ADDR_W (ADDR_W),
  .PROT_LO(PROT_LO),
  .PROT_HI(PROT_HI)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .fwd_wr_o  (fwd_wr_o),
  .unlocked_o(unlocked_o)
);

// File: tb/key_gate_tb.sv
`timescale 1ns/1ps
module key_gate_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int PROT_LO = 0;
  localparam int PROT_HI = 'h5C;
  localparam logic [31:0] M0 = 32'h83E7_0B13;
  localparam logic [31:0] M1 = 32'h95A4_F1E0;
  localparam logic [7:0]  A0 = 8'h6C;
  localparam logic [7:0]  A1 = 8'h70;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic fwd_wr_o, unlocked_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_k0 = '0, m_k1 = '0;

  always #4 clk_i = ~clk_i;

  key_gate #(.ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .fwd_wr_o(fwd_wr_o), .unlocked_o(unlocked_o));

  function automatic logic exp_unl();
    return (m_k0 == M0) && (m_k1 == M1);
  endfunction

  function automatic logic exp_fwd(logic we, logic [7:0] a);
    logic key, win;
    key = (a == A0) || (a == A1);
    win = (int'(a) >= PROT_LO) && (int'(a) <= PROT_HI);
    return we && !key && (!win || exp_unl());
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a == A0) return m_k0;
    if (a == A1) return m_k1;
    return 32'h0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic [7:0] a, logic [31:0] d, logic [7:0] ra, string tag);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = a; wr_data_i = d; rd_addr_i = ra;
    #1;
    check(tag, {31'b0, fwd_wr_o}, {31'b0, exp_fwd(we, a)});
    check("R2 unlocked", {31'b0, unlocked_o}, {31'b0, exp_unl()});
    check("R9 readback", rd_data_o, exp_rd(ra));
    @(posedge clk_i);
    if (we && a == A0) m_k0 = d;
    if (we && a == A1) m_k1 = d;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #20;
    // R1: state right after reset
    #1;
    check("R1 unlocked", {31'b0, unlocked_o}, 32'd0);
    rst_ni = 1'b1;
    cyc(1'b0, 8'h00, 32'h0, A0, "R1 idle");
    cyc(1'b0, 8'h00, 32'h0, A1, "R1 idle");
    cyc(1'b1, 8'h10, 32'hAAAA, 8'h00, "R1 locked protected write");
    // R2: forward order
    cyc(1'b1, A0, M0, A0, "R9 key write");
    cyc(1'b1, A1, M1, A1, "R9 key write");
    cyc(1'b1, 8'h20, 32'h1, A0, "R7 unlocked protected write");
    cyc(1'b1, 8'h5C, 32'h2, A1, "R7 window top");
    // R4: bad word to slot 1
    cyc(1'b1, A1, 32'h1234_5678, A1, "R9 key write");
    cyc(1'b1, 8'h00, 32'h3, A1, "R4 relocked window bottom");
    // R3: reverse order
    cyc(1'b1, A1, M1, A1, "R9 key write");
    cyc(1'b1, A0, M0, A0, "R9 key write");
    cyc(1'b1, 8'h04, 32'h4, A0, "R3 reverse unlock");
    // R8 while unlocked and locked
    cyc(1'b1, 8'h60, 32'h5, A0, "R8 outside");
    // R5: zero both
    cyc(1'b1, A0, 32'h0, A0, "R9 key write");
    cyc(1'b1, A1, 32'h0, A1, "R9 key write");
    cyc(1'b1, 8'h08, 32'h6, A0, "R5 zeroed locked");
    cyc(1'b1, 8'hFC, 32'h7, A0, "R8 outside locked");
    cyc(1'b1, 8'h68, 32'h8, 8'h68, "R8 below key");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned sel;
      logic [7:0] a, ra;
      logic [31:0] d;
      sel = $urandom_range(0, 9);
      d = $urandom();
      ra = 8'($urandom_range(0, 63) * 4);
      case (sel)
        0, 1: begin a = A0; d = ($urandom_range(0, 3) != 0) ? M0 : (($urandom_range(0, 1) != 0) ? 32'h0 : d); end
        2, 3: begin a = A1; d = ($urandom_range(0, 3) != 0) ? M1 : (($urandom_range(0, 1) != 0) ? 32'h0 : d); end
        4, 5, 6: a = 8'($urandom_range(0, 23) * 4);
        7, 8: a = 8'(32'h74 + $urandom_range(0, 34) * 4);
        default: a = 8'h64;
      endcase
      if (a == A0 || a == A1)            cyc(1'b1, a, d, ra, "R4 random key write");
      else if (int'(a) <= PROT_HI)       cyc(($urandom_range(0, 4) != 0), a, d, ra, exp_unl() ? "R7 random" : "R6 random");
      else                               cyc(1'b1, a, d, ra, "R8 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule